// File: doc/BRIEF.md
# Split-Precision Fixed-Point Multiply-Accumulate Cell

This cell multiplies a signed 32-bit fixed-point weight by an activation word and adds the product into a running sum. The activation word is read in one of two ways. In wide mode it is one signed 32-bit activation. In split mode it holds two signed 16-bit activations packed side by side, so each enabled cycle performs two multiply-accumulates. Both modes use the same pair of 32-by-16 multipliers. In wide mode the product from the upper activation half is shifted left by 16 and added to the product from the lower half, which gives the exact 64-bit product. In split mode the two products go to two separate lane sums.

A clear pulse starts a new dot product. It zeroes every sum and also captures the requested mode. The mode input has no effect at any other time, so a dot product cannot change mode partway through. Each sum has four guard bits, so sixteen worst-case products can be added without overflow. Rounding and rescaling of the finished sums are left to the logic that reads them.

Top module: `spmac_cell`

## Requirements
- R1: While `rst` is high and after it falls, all three sums read zero and `half_o` reads 0 (wide mode), until the first clear or enable.
- R2: A cycle with `clr_i` high zeroes all three sums at the next edge, even when `en_i` is also high. On that same edge the active mode takes the value of `half_i` (0 = wide, 1 = split).
- R3: In wide mode, each enabled cycle adds the exact signed product `weight_i * act_i` (both read as signed 32-bit) to `sum_wide_o`, and the new sum is visible after that clock edge.
- R4: In wide mode, bits [15:0] of the activation are treated as an unsigned low digit and bits [31:16] as a signed high digit. For example, `act_i = 0x0000FFFF` adds `weight_i * 65535`.
- R5: In split mode, each enabled cycle adds `weight_i * act_i[15:0]` to `sum_lane0_o` and `weight_i * act_i[31:16]` to `sum_lane1_o`. Both halves are read as signed 16-bit values.
- R6: A change of `half_i` without a clear has no effect: `half_o` and the way `act_i` is read stay the same.
- R7: A cycle with `en_i` and `clr_i` both low leaves all sums unchanged.
- R8: The sums of the mode that is not active stay at zero.
- R9: Sixteen accumulations of the most extreme products give exact results. In wide mode, 16 × (−2^31 × −2^31) = 2^66. In split mode, 16 × (−2^31 × −2^15) = 2^50 in each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Accumulate the current product(s) |
| clr_i | input | 1 | Zero all sums and capture the mode |
| half_i | input | 1 | Requested mode, sampled only on clear (1 = split) |
| weight_i | input | 32 | Signed fixed-point weight |
| act_i | input | 32 | One signed 32-bit activation, or two signed 16-bit activations |
| sum_wide_o | output | 68 | Wide-mode accumulated sum |
| sum_lane0_o | output | 52 | Split-mode sum of the low lane |
| sum_lane1_o | output | 52 | Split-mode sum of the high lane |
| half_o | output | 1 | Mode currently active |

## Verification
The assertions check on every cycle that a clear leaves all sums at zero, that idle cycles keep the sums unchanged, that the mode changes only on a clear, and that the sums of the inactive mode stay at zero. They also check that no lane product exceeds 48 bits and that no accumulation overflows its register. Only the bench's scenarios can show that the values themselves are right. For that the bench compares them with products computed at full width. It covers the unsigned treatment of the low digit in wide mode, the sign handling of each split lane, and the exact results after sixteen extreme products.

// File: rtl/spmac_pkg.sv
package spmac_pkg;
    localparam int W_BITS   = 32;
    localparam int A_BITS   = 32;
    localparam int H_BITS   = A_BITS / 2;
    localparam int N_LANES  = 2;
    localparam int GUARD    = 4;
    localparam int LANE_P   = W_BITS + H_BITS;
    localparam int FULL_P   = W_BITS + A_BITS;
    localparam int LANE_ACC = LANE_P + GUARD;
    localparam int FULL_ACC = FULL_P + GUARD;

    typedef enum logic {
        PREC_FULL = 1'b0,
        PREC_HALF = 1'b1
    } prec_t;

    typedef struct packed {
        logic [LANE_P-1:0] hi;
        logic [LANE_P-1:0] lo;
    } lane_prod_t;

    function automatic logic [FULL_P-1:0] merge_lanes(lane_prod_t p);
        logic [FULL_P-1:0] hi_x;
        logic [FULL_P-1:0] lo_x;
        hi_x = {{(FULL_P-LANE_P){p.hi[LANE_P-1]}}, p.hi};
        lo_x = {{(FULL_P-LANE_P){p.lo[LANE_P-1]}}, p.lo};
        return (hi_x << H_BITS) + lo_x;
    endfunction
endpackage

// File: rtl/spmac_lane_mul.sv
module spmac_lane_mul #(
    parameter int W = 32,
    parameter int H = 16
) (
    input  logic [W-1:0]   w_i,
    input  logic [H-1:0]   a_i,
    input  logic           a_signed_i,
    output logic [W+H-1:0] p_o
);
    localparam int PW = W + H + 1;

    logic signed [PW-1:0] wx;
    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] prod;

    assign wx   = {{(PW-W){w_i[W-1]}}, w_i};
    assign ax   = {{(PW-H){a_signed_i & a_i[H-1]}}, a_i};
    assign prod = wx * ax;
    assign p_o  = prod[W+H-1:0];

    // R9: a lane product always fits the 48-bit lane width
    always_comb begin
        if (!$isunknown(prod)) begin
            assert_lane_fits_R9: assert (prod[PW-1] == prod[PW-2]);
        end
    end
endmodule

// File: rtl/spmac_acc.sv
module spmac_acc #(
    parameter int ACC_W = 52,
    parameter int IN_W  = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [IN_W-1:0]  addend_i,
    output logic [ACC_W-1:0] sum_o
);
    logic [ACC_W-1:0] sum_q;
    logic [ACC_W:0]   nxt;

    assign nxt = {sum_q[ACC_W-1], sum_q}
               + {{(ACC_W+1-IN_W){addend_i[IN_W-1]}}, addend_i};

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sum_q <= '0;
        end else if (en_i) begin
            sum_q <= nxt[ACC_W-1:0];
        end
    end

    assign sum_o = sum_q;

    // R9: an enabled accumulation never leaves the signed range
    always_comb begin
        if (en_i && !clr_i && !rst && !$isunknown(nxt)) begin
            assert_no_overflow_R9: assert (nxt[ACC_W] == nxt[ACC_W-1]);
        end
    end

    // R7: idle cycles keep the sum
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !en_i) |=> $stable(sum_q));
endmodule

// File: rtl/spmac_cell.sv
module spmac_cell
    import spmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                clr_i,
    input  logic                half_i,
    input  logic [W_BITS-1:0]   weight_i,
    input  logic [A_BITS-1:0]   act_i,
    output logic [FULL_ACC-1:0] sum_wide_o,
    output logic [LANE_ACC-1:0] sum_lane0_o,
    output logic [LANE_ACC-1:0] sum_lane1_o,
    output logic                half_o
);
    prec_t            mode_q;
    lane_prod_t       prods;
    logic [LANE_P-1:0] lane_p   [N_LANES];
    logic [LANE_ACC-1:0] lane_s [N_LANES];
    logic             wide_en;
    logic             lane_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PREC_FULL;
        end else if (clr_i) begin
            mode_q <= prec_t'(half_i);
        end
    end

    assign wide_en = en_i && (mode_q == PREC_FULL);
    assign lane_en = en_i && (mode_q == PREC_HALF);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        spmac_lane_mul #(.W(W_BITS), .H(H_BITS)) i_mul (
            .w_i        (weight_i),
            .a_i        (act_i[g*H_BITS +: H_BITS]),
            .a_signed_i ((g == N_LANES-1) || (mode_q == PREC_HALF)),
            .p_o        (lane_p[g])
        );
        spmac_acc #(.ACC_W(LANE_ACC), .IN_W(LANE_P)) i_acc (
            .clk      (clk),
            .rst      (rst),
            .clr_i    (clr_i),
            .en_i     (lane_en),
            .addend_i (lane_p[g]),
            .sum_o    (lane_s[g])
        );
    end

    assign prods.lo = lane_p[0];
    assign prods.hi = lane_p[1];

    spmac_acc #(.ACC_W(FULL_ACC), .IN_W(FULL_P)) i_wide_acc (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr_i),
        .en_i     (wide_en),
        .addend_i (merge_lanes(prods)),
        .sum_o    (sum_wide_o)
    );

    assign sum_lane0_o = lane_s[0];
    assign sum_lane1_o = lane_s[1];
    assign half_o      = (mode_q == PREC_HALF);

    // R2: a clear leaves every sum at zero
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (sum_wide_o == '0 && sum_lane0_o == '0 && sum_lane1_o == '0));

    // R6: mode only moves on a clear
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> $stable(half_o));

    // R8: sums of the inactive mode stay zero
    assert_inactive_lane_R8: assert property (@(posedge clk) disable iff (rst)
        !half_o |-> (sum_lane0_o == '0 && sum_lane1_o == '0));
    assert_inactive_wide_R8: assert property (@(posedge clk) disable iff (rst)
        half_o |-> (sum_wide_o == '0));
endmodule

// File: tb/test_spmac_cell.sv
`timescale 1ns/1ps
module test_spmac_cell;
    import spmac_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, clr = 1'b0, half = 1'b0;
    logic [W_BITS-1:0]   weight = '0;
    logic [A_BITS-1:0]   act = '0;
    logic [FULL_ACC-1:0] sum_wide;
    logic [LANE_ACC-1:0] sum_l0, sum_l1;
    logic                half_q;

    logic [FULL_ACC-1:0] e_wide = '0;
    logic [LANE_ACC-1:0] e_l0 = '0, e_l1 = '0;
    logic                e_half = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spmac_cell i_spmac_cell (
        .clk(clk), .rst(rst), .en_i(en), .clr_i(clr), .half_i(half),
        .weight_i(weight), .act_i(act),
        .sum_wide_o(sum_wide), .sum_lane0_o(sum_l0), .sum_lane1_o(sum_l1),
        .half_o(half_q)
    );

    function automatic logic [FULL_ACC-1:0] ref_wide(logic [31:0] w, logic [31:0] a);
        logic signed [FULL_ACC-1:0] wx, ax;
        wx = $signed({{(FULL_ACC-32){w[31]}}, w});
        ax = $signed({{(FULL_ACC-32){a[31]}}, a});
        return wx * ax;
    endfunction

    function automatic logic [LANE_ACC-1:0] ref_lane(logic [31:0] w, logic [15:0] a);
        logic signed [LANE_ACC-1:0] wx, ax;
        wx = $signed({{(LANE_ACC-32){w[31]}}, w});
        ax = $signed({{(LANE_ACC-16){a[15]}}, a});
        return wx * ax;
    endfunction

    task automatic check(string tag, logic [FULL_ACC-1:0] got, logic [FULL_ACC-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(e_half ? "R8 wide" : {tag, " wide"}, sum_wide, e_wide);
        check(e_half ? {tag, " lane0"} : "R8 lane0", FULL_ACC'(sum_l0), FULL_ACC'(e_l0));
        check(e_half ? {tag, " lane1"} : "R8 lane1", FULL_ACC'(sum_l1), FULL_ACC'(e_l1));
        check({tag, " mode"}, FULL_ACC'(half_q), FULL_ACC'(e_half));
    endtask

    task automatic cyc(bit e, bit c, bit m, logic [31:0] w, logic [31:0] a, string tag);
        @(negedge clk);
        en = e; clr = c; half = m; weight = w; act = a;
        @(posedge clk);
        if (c) begin
            e_wide = '0; e_l0 = '0; e_l1 = '0; e_half = m;
        end else if (e) begin
            if (!e_half) e_wide = e_wide + ref_wide(w, a);
            else begin
                e_l0 = e_l0 + ref_lane(w, a[15:0]);
                e_l1 = e_l1 + ref_lane(w, a[31:16]);
            end
        end
        #(CLK_PERIOD/4);
        compare_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all("R1 in reset");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #(CLK_PERIOD/4);
        compare_all("R1 after reset");

        // wide mode, random, some idle cycles
        cyc(0, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 40; i++) begin
            bit e = ($urandom % 4) != 0;
            cyc(e, 0, 0, $urandom, $urandom, e ? "R3" : "R7");
        end
        // wide corners: unsigned low digit, minus one, extremes
        cyc(1, 1, 0, 32'h1234_5678, 32'h0, "R2 en+clr");
        cyc(1, 0, 0, 32'h0000_0003, 32'h0000_FFFF, "R4");
        cyc(1, 0, 0, 32'hFFFF_FFFD, 32'h0000_8000, "R4");
        cyc(1, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3");
        cyc(1, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF, "R3");
        // mode request without clear is ignored
        cyc(1, 0, 1, 32'h0001_0001, 32'h8001_7FFF, "R6");

        // split mode, random
        cyc(0, 1, 1, 0, 0, "R2");
        for (int i = 0; i < 40; i++) begin
            bit e = ($urandom % 4) != 0;
            cyc(e, 0, 1, $urandom, $urandom, e ? "R5" : "R7");
        end
        cyc(1, 0, 1, 32'hFFFF_FFFF, 32'h8000_FFFF, "R5");
        cyc(1, 0, 0, 32'h0000_0005, 32'hFFFF_0001, "R6");
        cyc(0, 0, 0, 32'h1111_1111, 32'h2222_2222, "R7");

        // overflow headroom
        cyc(0, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 16; i++)
            cyc(1, 0, 0, 32'h8000_0000, 32'h8000_0000, "R9");
        check("R9 wide total", sum_wide, FULL_ACC'(1) << 66);
        cyc(0, 1, 1, 0, 0, "R2");
        for (int i = 0; i < 16; i++)
            cyc(1, 0, 1, 32'h8000_0000, 32'h8000_8000, "R9");
        check("R9 lane total", FULL_ACC'(sum_l1), FULL_ACC'(1) << 50);

        // random mix with clears and mode switches
        for (int i = 0; i < 200; i++) begin
            bit c = ($urandom % 10) == 0;
            bit e = ($urandom % 3) != 0;
            bit m = $urandom % 2;
            cyc(e, c, m, $urandom, $urandom,
                c ? "R2" : (!e ? "R7" : (e_half ? "R5" : "R3")));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule